// File: doc/BRIEF.md
# Cascaded-Stage Arithmetic Logic Unit

This block is a combinational arithmetic-logic unit. Two operands enter, each passes through an optional clear step and then an optional bitwise-invert step. The two conditioned values are then either summed or bitwise ANDed. The combined value may be inverted once more before it leaves the block.

Two flags describe the final result. One is high when the result is zero, and the other is high when the result is negative. No function has its own encoding. Every operation, including the constants 0, 1 and -1, comes from a particular setting of six independent stage controls. The control field is meant to be wired directly from six adjacent bits of an instruction word, so a decoder elsewhere only has to slice that field out.

The block has no clock and no state. Its outputs follow its inputs after combinational delay.

Top module: `cascade_alu`

## Requirements
- R1: The control port `ctl` is a 6-bit vector with the following bit positions. `ctl[5]` clears x, `ctl[4]` inverts x, `ctl[3]` clears y, `ctl[2]` inverts y, `ctl[1]` selects add (1) or AND (0), and `ctl[0]` inverts the output.
- R2: When `ctl[5]` is set, x is replaced by zero. The invert from `ctl[4]` is applied after this, so setting both controls gives all ones.
- R3: When `ctl[3]` is set, y is replaced by zero. The invert from `ctl[2]` is applied after this, so setting both controls gives all ones.
- R4: With `ctl[1]` = 1, the conditioned operands are added modulo 2^WIDTH. There is no carry out.
- R5: With `ctl[1]` = 0, the conditioned operands are combined by bitwise AND.
- R6: With `ctl[0]` = 1, the combined value is bitwise inverted before it reaches `res`.
- R7: `zr` is 1 exactly when every bit of `res` is 0.
- R8: `ng` equals the most significant bit of `res`. It reads the final value, after the output invert.
- R9: For any operands, `ctl` = 6'b101010 gives 0, 6'b111111 gives 1, and 6'b111010 gives all ones (-1).
- R10: `ctl` = 6'b000010 gives x+y and `ctl` = 6'b000000 gives x AND y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | First operand, two's complement |
| y | input | WIDTH | Second operand, two's complement |
| ctl | input | 6 | Stage controls: clear-x, invert-x, clear-y, invert-y, add/AND, invert-out |
| res | output | WIDTH | Result |
| zr | output | 1 | High when res is zero |
| ng | output | 1 | High when res is negative |

## Verification
The bench builds the unit twice. The first copy uses the default WIDTH of 16 and runs the eighteen standard computations, the signed wrap boundaries, and random operand sweeps. The second copy uses WIDTH of 4, which is small enough to visit every combination of control setting and operand pair. That exhaustive pass covers every stage interaction and every flag case, including the most-negative value and each carry wrap.

// File: rtl/cascade_alu.sv
module cascade_alu #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic [5:0]       ctl,
  output logic [WIDTH-1:0] res,
  output logic             zr,
  output logic             ng
);
  localparam int CLR_X = 5;
  localparam int INV_X = 4;
  localparam int CLR_Y = 3;
  localparam int INV_Y = 2;
  localparam int SEL_ADD = 1;
  localparam int INV_OUT = 0;

  logic [WIDTH-1:0] xz, xc, yz, yc, comb;

  assign xz = ctl[CLR_X] ? '0 : x;
  assign xc = ctl[INV_X] ? ~xz : xz;
  assign yz = ctl[CLR_Y] ? '0 : y;
  assign yc = ctl[INV_Y] ? ~yz : yz;

  assign comb = ctl[SEL_ADD] ? (xc + yc) : (xc & yc);
  assign res  = ctl[INV_OUT] ? ~comb : comb;

  assign zr = ~|res;
  assign ng = res[WIDTH-1];
endmodule

module cascade_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] x,
  input logic [WIDTH-1:0] y,
  input logic [5:0]       ctl,
  input logic [WIDTH-1:0] res,
  input logic             zr,
  input logic             ng
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    // R9
    const_zero_chk: assert (ctl != 6'b101010 || res == '0);
    // R9
    const_one_chk: assert (ctl != 6'b111111 || res == ONE);
    // R9
    const_ones_chk: assert (ctl != 6'b111010 || res == {WIDTH{1'b1}});
    // R10
    sum_chk: assert (ctl != 6'b000010 || res == WIDTH'(x + y));
    // R10
    and_chk: assert (ctl != 6'b000000 || res == (x & y));
    // R6
    inv_sum_chk: assert (ctl != 6'b000011 || res == ~WIDTH'(x + y));
    // R7
    zero_flag_chk: assert (zr == (res == '0));
    // R8
    neg_flag_chk: assert (ng == ($signed(res) < 0));
  end
endmodule

bind cascade_alu cascade_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/cascade_alu_bench.sv
module cascade_alu_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] x, y, res;
  logic [5:0]  ctl;
  logic        zr, ng;

  logic [3:0]  x4, y4, res4;
  logic [5:0]  ctl4;
  logic        zr4, ng4;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cascade_alu #(.WIDTH(16)) u_cascade_alu (
    .x(x), .y(y), .ctl(ctl), .res(res), .zr(zr), .ng(ng));

  cascade_alu #(.WIDTH(4)) u_cascade_alu_w4 (
    .x(x4), .y(y4), .ctl(ctl4), .res(res4), .zr(zr4), .ng(ng4));

  // {ctl, x, y, expected}
  localparam logic [53:0] VEC [18] = '{
    {6'b101010, 16'h0013, 16'h0007, 16'h0000},
    {6'b111111, 16'h0013, 16'h0007, 16'h0001},
    {6'b111010, 16'h0013, 16'h0007, 16'hFFFF},
    {6'b001100, 16'h0013, 16'h0007, 16'h0013},
    {6'b110000, 16'h0013, 16'h0007, 16'h0007},
    {6'b001101, 16'h0013, 16'h0007, 16'hFFEC},
    {6'b110001, 16'h0013, 16'h0007, 16'hFFF8},
    {6'b001111, 16'h0013, 16'h0007, 16'hFFED},
    {6'b110011, 16'h0013, 16'h0007, 16'hFFF9},
    {6'b011111, 16'h0013, 16'h0007, 16'h0014},
    {6'b110111, 16'h0013, 16'h0007, 16'h0008},
    {6'b001110, 16'h0013, 16'h0007, 16'h0012},
    {6'b110010, 16'h0013, 16'h0007, 16'h0006},
    {6'b000010, 16'h0013, 16'h0007, 16'h001A},
    {6'b010011, 16'h0013, 16'h0007, 16'h000C},
    {6'b000111, 16'h0013, 16'h0007, 16'hFFF4},
    {6'b000000, 16'h0013, 16'h0007, 16'h0003},
    {6'b010101, 16'h0013, 16'h0007, 16'h0017}
  };

  function automatic logic [15:0] model(input logic [5:0] c, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] p, q, r;
    p = c[5] ? 16'h0000 : a;
    if (c[4]) p = ~p;
    q = c[3] ? 16'h0000 : b;
    if (c[2]) q = ~q;
    r = c[1] ? p + q : p & q;
    if (c[0]) r = ~r;
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (ctl=%b x=%h y=%h)", tag, got, exp, ctl, x, y);
    end
  endtask

  task automatic apply(input logic [5:0] c, input logic [15:0] a, input logic [15:0] b);
    @(posedge clk);
    ctl = c; x = a; y = b;
    @(negedge clk);
  endtask

  task automatic check_flags;
    check("R7 zr", {15'b0, zr}, {15'b0, res == 16'h0000});
    check("R8 ng", {15'b0, ng}, {15'b0, res[15]});
  endtask

  initial begin
    ctl = 6'b101010; x = 16'h1234; y = 16'h5678;
    ctl4 = '0; x4 = '0; y4 = '0;
    @(negedge clk);
    check("R9 initial zero", res, 16'h0000);
    check("R7 initial zr", {15'b0, zr}, 16'h0001);

    for (int i = 0; i < 18; i++) begin
      apply(VEC[i][53:48], VEC[i][47:32], VEC[i][31:16]);
      check("R1 table", res, VEC[i][15:0]);
      check_flags();
    end

    // R4 signed wrap to most negative, and wrap to zero
    apply(6'b000010, 16'h7FFF, 16'h0001);
    check("R4 wrap", res, 16'h8000);
    check("R8 ng wrap", {15'b0, ng}, 16'h0001);
    apply(6'b000010, 16'hFFFF, 16'h0001);
    check("R4 carry drop", res, 16'h0000);
    check("R7 zr wrap", {15'b0, zr}, 16'h0001);

    // R2 R3 clearing happens before inversion
    apply(6'b110000, 16'hABCD, 16'h0000);
    check("R2 clr then inv x", res, 16'h0000);
    apply(6'b001100, 16'h0000, 16'h1357);
    check("R3 clr then inv y", res, 16'h0000);
    apply(6'b100000, 16'hFFFF, 16'h00F0);
    check("R2 clear x", res, 16'h0000);
    apply(6'b001000, 16'h0F0F, 16'hFFFF);
    check("R3 clear y", res, 16'h0000);

    // R5 R6 AND and output inversion
    apply(6'b000000, 16'hF0F0, 16'h3C3C);
    check("R5 and", res, 16'h3030);
    apply(6'b000001, 16'hF0F0, 16'h3C3C);
    check("R6 nand", res, 16'hCFCF);
    check("R8 ng after invert", {15'b0, ng}, 16'h0001);

    // R9 R10 constants and arithmetic for random operands
    for (int i = 0; i < 200; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      apply(6'b101010, a, b); check("R9 zero", res, 16'h0000);
      apply(6'b111111, a, b); check("R9 one", res, 16'h0001);
      apply(6'b111010, a, b); check("R9 minus one", res, 16'hFFFF);
      apply(6'b000010, a, b); check("R10 sum", res, 16'(a + b));
      apply(6'b000000, a, b); check("R10 and", res, a & b);
      apply(6'($urandom), a, b); check("R1 random ctl", res, model(ctl, a, b));
      check_flags();
    end

    // exhaustive narrow instance
    for (int c = 0; c < 64; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [15:0] m;
          @(posedge clk);
          ctl4 = 6'(c); x4 = 4'(a); y4 = 4'(b);
          @(negedge clk);
          m = model(6'(c), 16'(a), 16'(b));
          checks++;
          if (res4 !== m[3:0] || zr4 !== (m[3:0] == 4'h0) || ng4 !== m[3]) begin
            fails++;
            $display("FAIL R1 w4: ctl=%b x=%h y=%h got %h/%b/%b expected %h/%b/%b",
                     ctl4, x4, y4, res4, zr4, ng4, m[3:0], m[3:0] == 4'h0, m[3]);
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule